// File: doc/BRIEF.md
# Serial Control Register Slave with Block Transfers

This block is a two-wire serial slave that holds seven 8-bit control registers and presents them on a parallel bus to the logic they configure. A host writes them with a block-write sequence: after the write address it must send two leading bytes (a command code and a byte count). The slave acknowledges both and throws their values away. The data bytes that follow fill the registers in ascending order, starting at register 0. A host reads them with a block-read sequence: the slave answers with a byte count and then streams every register in order.

The serial lines are sampled by the system clock through two-stage synchronisers. Start and stop conditions are taken from SDA edges while SCL is high. The slave only ever pulls SDA low through an open-drain enable. A low-active reset loads every register with a parameter default. The bus runs at standard-mode rates, so many system clocks pass in every SCL phase.

Top module: `smbus_blkreg_slave`

## Requirements
- R1: The 8-bit address byte 0xD2 (7-bit address 0x69, bit 0 = 0) opens a write and 0xD3 (bit 0 = 1) opens a read, and the slave acknowledges both.
- R2: In a write, the first two bytes after the address are acknowledged and their values are discarded, leaving every register unchanged.
- R3: Write data bytes land in register 0, 1, 2 and so on, in that order. Register k appears on regs_o[8k+7:8k]. Each byte is acknowledged, and the slave never drives SDA while the host sends bits.
- R4: A stop after any complete data byte ends the write. Registers already written keep their new values and the rest are unchanged.
- R5: A read returns first the byte count 7, then registers 0 through 6 in order, each sent MSB first.
- R6: After reset, regs_o equals the REG_INIT parameter.
- R7: Write data bytes beyond register 6 are acknowledged and ignored.
- R8: A host NACK during a read ends the transfer, and the slave keeps SDA released until the next start or stop.
- R9: A repeated start restarts the byte sequence, so the next write data byte goes to register 0 again.
- R10: Any other address byte gets no acknowledge, and the slave ignores the bus until the next start.
- R11: The slave turns its SDA pull-down on only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the bus data line is pulled low |
| regs_o | output | 56 | Register contents, register k in bits 8k+7:8k |

## Verification
The bench goes after the two dummy bytes with values that differ from the defaults. A slave that stored them would shift every register by two places or corrupt register 0, and the compare made on every clock would catch it at once. Writes that run past register 6 and writes cut short by an early stop show up as registers that change when they must not, or keep stale values. A repeated start in the middle of a write and a read ended early by a NACK test the byte-counter reset and the release of SDA. A slave that skipped either would store into the wrong register or hold the line low. A foreign address followed by data bytes must draw no acknowledge and change no register.

// File: rtl/smbus_blkreg_slave.sv
module smbus_blkreg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 7,
  parameter logic [8*NUM_REGS-1:0] REG_INIT = 56'h07_F3_A5_00_FF_3C_81
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] regs_o
);
  localparam int SAT = NUM_REGS + 2;
  localparam int CW  = $clog2(SAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_MACK} st_t;

  st_t st;
  logic [2:0] scl_s, sda_s;
  logic [7:0] sh, txsh, nxt;
  logic [3:0] bitcnt;
  logic [CW-1:0] bytecnt;
  logic rd, nack;
  logic [8*NUM_REGS-1:0] regs_q;
  int wr_idx, rd_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_q    = scl_s[1];
  wire sda_q    = sda_s[1];
  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start_c  = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_c   = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];

  assign wr_idx = int'(bytecnt) - 2;
  assign rd_idx = int'(bytecnt);
  assign nxt    = (rd_idx < NUM_REGS) ? regs_q[8*rd_idx +: 8] : 8'hFF;
  assign regs_o = regs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      txsh    <= '0;
      bitcnt  <= '0;
      bytecnt <= '0;
      rd      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      regs_q  <= REG_INIT;
    end else if (start_c) begin
      st      <= S_ADDR;
      bitcnt  <= '0;
      bytecnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_RX: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                rd     <= sh[0];
                sda_oe <= 1'b1;
                st     <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              if (wr_idx >= 0 && wr_idx < NUM_REGS) regs_q[8*wr_idx +: 8] <= sh;
              if (bytecnt != CW'(SAT)) bytecnt <= bytecnt + 1'b1;
              sda_oe <= 1'b1;
              st     <= S_WACK;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (rd) begin
            txsh   <= 8'(NUM_REGS);
            sda_oe <= ~(8'(NUM_REGS) >> 7);
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_RX;
          end
        end
        S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          st     <= S_RX;
        end
        S_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) nack <= sda_q;
          else if (scl_fall) begin
            if (nack) st <= S_IDLE;
            else begin
              txsh   <= nxt;
              sda_oe <= ~nxt[7];
              if (bytecnt != CW'(SAT)) bytecnt <= bytecnt + 1'b1;
              st     <= S_TX;
            end
          end
        end
        default: ;
      endcase
    end

  p_oe_on_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  p_quiet_while_host_sends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && scl_rise) |-> !sda_oe);

  p_regs_only_from_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(regs_q) |-> ($past(st) == S_RX && $past(bytecnt) >= CW'(2)));

  p_count_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_AACK && st == S_TX) |-> txsh == 8'(NUM_REGS));

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);
endmodule

// File: tb/smbus_blkreg_slave_bench.sv
module smbus_blkreg_slave_bench;
  localparam int TQ = 20;
  localparam logic [55:0] INIT = 56'h07_F3_A5_00_FF_3C_81;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [55:0] regs_o;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  logic [7:0] model [7];
  bit hold = 1'b0, done = 1'b0, prev_oe = 1'b0;

  always #4 clk = ~clk;

  smbus_blkreg_slave u_smbus_blkreg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs_o));

  function automatic logic [55:0] packed_model();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!hold) begin
        checks++;
        if (regs_o !== packed_model()) begin
          errors++;
          $display("FAIL R2/R3/R4/R7/R10 regs: actual %h expected %h", regs_o, packed_model());
        end
      end
      if (sda_oe && !prev_oe) chk("R11 pull-down turned on with SCL high", {31'd0, m_scl}, 32'd0);
      prev_oe = sda_oe;
    end
  end

  task automatic wq(); repeat (TQ) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input int upd, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) hold = 1'b1;
      put_bit(b[i]);
    end
    if (upd >= 0 && upd < 7) model[upd] = b;
    hold = 1'b0;
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit last);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(last);
  endtask

  task automatic write_body(input logic [7:0] d [$], input string tag);
    bit ack;
    send_byte(8'hD2, -1, ack); chk("R1 write address ack", ack, 1);
    send_byte(8'hAA, -1, ack); chk("R2 command byte ack", ack, 1);
    send_byte(8'h55, -1, ack); chk("R2 count byte ack", ack, 1);
    foreach (d[i]) begin
      send_byte(d[i], i, ack);
      chk(i < 7 ? {tag, " data ack"} : "R7 extra byte ack", ack, 1);
    end
  endtask

  task automatic read_back(input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, -1, ack); chk("R1 read address ack", ack, 1);
    recv_byte(b, 1'b0); chk("R5 byte count", b, 7);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k == n - 1);
      chk($sformatf("R5 register %0d", k), b, model[k]);
    end
    repeat (5) @(negedge clk);
    chk("R8 SDA released after NACK", sda_oe, 0);
    wq();
    chk("R8 SDA still released", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (TQ * 400) @(posedge clk);
    ;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] q [$];
    for (int k = 0; k < 7; k++) model[k] = INIT[8*k +: 8];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 defaults after reset", regs_o[31:0], INIT[31:0]);
    chk("R6 defaults after reset (upper)", {8'd0, regs_o[55:32]}, {8'd0, INIT[55:32]});
    chk("R6 SDA released after reset", sda_oe, 0);

    q = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76, 8'h99, 8'hC3};
    bus_start(); write_body(q, "R3"); bus_stop();
    read_back(7);

    q = '{8'hE1, 8'hD2, 8'h0F};
    bus_start(); write_body(q, "R4"); bus_stop();
    read_back(7);

    bus_start();
    send_byte(8'hA4, -1, ack); chk("R10 foreign address not acked", ack, 0);
    send_byte(8'hD2, -1, ack); chk("R10 later byte ignored", ack, 0);
    send_byte(8'h5A, -1, ack); chk("R10 data ignored", ack, 0);
    chk("R10 SDA released", sda_oe, 0);
    bus_stop();

    bus_start(); q = '{8'h11}; write_body(q, "R3");
    bus_start(); q = '{8'h22, 8'h33}; write_body(q, "R9");
    bus_stop();
    chk("R9 register 0 after repeated start", regs_o[7:0], 8'h22);
    chk("R9 register 1 after repeated start", regs_o[15:8], 8'h33);

    read_back(2);
    repeat (10) @(negedge clk);
    chk("R4 register 6 unchanged", regs_o[55:48], 8'h76);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule